// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a synchronous host and an asynchronous 256K x 16 DRAM with extended data-out page mode. The host presents one request at a time on a valid/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and two byte enables. The controller turns each accepted request into a sequence of row strobe, column strobes, write enable and output enable on a shared 9-bit address bus. It puts the upper nine address bits out as the row and the lower nine bits as the column.

After an access the row stays open. A later request to the same row goes straight to a column cycle and skips the row phase. The page closes when a request misses the row, when an external refresh sequencer asks for the bus, or when an internal age limit is reached. That limit keeps the row strobe low for no longer than the part allows. Each byte lane has its own column strobe, so a single byte is written or read by pulsing only that lane's strobe. Read data is captured after the column strobe has gone high again. This depends on the part holding its outputs until the next column strobe falls. Every DRAM timing limit is a parameter counted in controller clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, the row strobe, both column strobes, write enable and output enable are high, the data driver is off, and `refresh_gnt`, `rsp_valid` and `rsp_err` are low.
- R2: Bits 17:9 of the request address are on `dram_addr` when the row strobe falls. Bits 8:0 are on `dram_addr` when a column strobe falls.
- R3: `req_be[0]` selects the lower column strobe (data bits 7:0) and `req_be[1]` selects the upper one (bits 15:8). Only the selected lanes are pulsed. A request with `req_be` = 2'b00 is accepted and then answered with a one-cycle `rsp_err` in the cycle after the accepting edge. It pulses no strobe and changes no memory.
- R4: A read that starts with the row closed raises `rsp_valid` for one cycle, three rising edges after the accepting edge. A read that hits the open row raises it two edges after. Responses come back in request order with the addressed bytes.
- R5: While the page is open and no refresh is pending, a request to the same row is accepted without the row strobe rising.
- R6: A request to a different row is not accepted while the page is open. The row strobe first goes high for at least `RP_CYC` cycles, and then the new row is opened.
- R7: Writes are early writes: write enable is low only in cycles where a column strobe is low, output enable is then high, and write data is driven.
- R8: Read data is sampled at the clock edge that ends the column precharge phase, with both column strobes high and the row strobe still low.
- R9: While `refresh_req` is high, no request is accepted and the open page is closed. `refresh_gnt` is high only while the row and column strobes are all high, and it drops once `refresh_req` falls.
- R10: The row strobe never stays low for more than `PAGE_MAX_CYC` cycles. An idle open page is closed on its own.
- R11: The row strobe stays low for at least `RAS_MIN_CYC` cycles and precharges for at least `RP_CYC` cycles. A column strobe falls only after the row strobe has been low for at least `RCD_CYC` cycles, stays low for at least `CAS_CYC` cycles, and precharges for at least `CP_CYC` cycles. A column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper nine bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Pulse for a rejected request with no byte enabled |
| refresh_req | input | 1 | Refresh sequencer asks for the DRAM |
| refresh_gnt | output | 1 | DRAM strobes released to the sequencer |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower lane column strobe, active low |
| dram_ucas_n | output | 1 | Upper lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Enables the pad drivers for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The bench goes after the edges of the page logic. It checks a hit that follows a write, byte writes that must leave the other lane untouched, and a miss that arrives while the page is open. A controller that fails to compare rows would return data from the wrong row, and one that skips precharge would trip the cycle-count timing monitor. A refresh request is raised while a same-row request waits, to catch a controller that slips one more access into a page it should be closing. An idle page is left open past the age limit to show the watchdog closes it. A rejected all-disabled request is followed by a read-back, which shows whether any strobe leaked to memory. The response latency is predicted per request from the bench's own view of whether the page is open, so a controller that reports a hit as a miss, or the reverse, is off by one cycle and gets flagged.

// File: rtl/edo_pkg.sv
// Shared types for the EDO DRAM controller.
package edo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, precharged, page closed
        ST_ROW,    // row strobe low, row address on the bus
        ST_COL,    // column strobe(s) low
        ST_CP,     // column precharge, read capture at its end
        ST_OPEN,   // page open, waiting for a hit, miss or close
        ST_PRE,    // row precharge after closing the page
        ST_REF     // bus handed to the refresh sequencer
    } edo_state_t;
endpackage

// File: rtl/edo_phase_timer.sv
// Down-counter that times one strobe phase.
// Assumes: load is pulsed on entry to a phase with (cycles - 1); done is
// high in the last cycle of the phase.
module edo_phase_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_page_guard.sv
// Holds the open row, compares incoming rows, and tracks how long the row
// strobe has been low.
// Assumes: open is high exactly while the row strobe is low.
module edo_page_guard #(
    parameter int ROW_W        = 9,
    parameter int PAGE_MAX_CYC = 4000,
    parameter int RAS_MIN_CYC  = 2,
    parameter int LIMIT        = 3990
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open,
    input  logic             capture,
    input  logic [ROW_W-1:0] cap_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic [ROW_W-1:0] row_q,
    output logic             hit,
    output logic             expired,
    output logic             ras_min_ok
);
    localparam int AGE_W = $clog2(PAGE_MAX_CYC + 2);
    logic [AGE_W-1:0] age;

    // Remember the row that the current page was opened with.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_q <= '0;
        else if (capture) row_q <= cap_row;
    end

    // Count cycles that have passed with the row strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n || !open) age <= '0;
        else if (age != '1)  age <= age + 1'b1;
    end

    assign hit        = (row_q == cmp_row);
    assign expired    = (age >= AGE_W'(LIMIT));
    assign ras_min_ok = (age >= AGE_W'(RAS_MIN_CYC - 1));

    // R10: the row strobe never outlives the page-mode maximum.
    a_r10_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> (age < AGE_W'(PAGE_MAX_CYC)));
endmodule

// File: rtl/edo_lane_strobe.sv
// Per-lane column strobe decode: one active-low strobe for each enabled byte.
// Assumes: cas_phase is high only in the column strobe phase.
module edo_lane_strobe #(
    parameter int LANES = 2
) (
    input  logic             cas_phase,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cas_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_n[i] = !(cas_phase && be[i]);
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
// EDO page-mode DRAM controller, top level.
// Turns valid/ready word or byte requests into row/column strobe sequences.
// It keeps the page open across hits and yields the bus to a refresh
// sequencer. Assumes a 16-bit part with two byte lanes and timing limits
// given in controller clock cycles.
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 16,
    parameter int RCD_CYC      = 1,
    parameter int RAS_MIN_CYC  = 2,
    parameter int RP_CYC       = 2,
    parameter int CAS_CYC      = 1,
    parameter int CP_CYC       = 1,
    parameter int PAGE_MAX_CYC = 4000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err,
    input  logic                   refresh_req,
    output logic                   refresh_gnt,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [COL_W-1:0]       dram_addr,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int LANES  = DATA_W / 8;
    localparam int PH_MAX = (RCD_CYC > RP_CYC ? RCD_CYC : RP_CYC)
                          + CAS_CYC + CP_CYC;
    localparam int TW     = $clog2(PH_MAX + 1);
    localparam int LIMIT  = PAGE_MAX_CYC - CAS_CYC - CP_CYC - 2;

    edo_state_t        state, state_d;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              cap_row, cap_req;
    logic [ROW_W-1:0]  row_q;
    logic              hit, expired, ras_min_ok;
    logic              wr_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q, cas_n;
    logic              legal_in, accept, close_req, open_ready;

    assign legal_in   = |req_be;
    assign accept     = req_valid && req_ready;
    assign close_req  = refresh_req || expired || (req_valid && legal_in && !hit);
    assign open_ready = !refresh_req && !expired && (!legal_in || hit);

    // Ready only where a new request can start without a strobe conflict.
    always_comb begin
        case (state)
            ST_IDLE: req_ready = !refresh_req;
            ST_OPEN: req_ready = open_ready;
            default: req_ready = 1'b0;
        endcase
    end

    // Next-state and phase-timer load decisions.
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_row  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (refresh_req) begin
                    state_d = ST_REF;
                end else if (accept && legal_in) begin
                    state_d  = ST_ROW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RCD_CYC - 1);
                    cap_row  = 1'b1;
                end
            end
            ST_ROW: if (tmr_done) begin
                state_d  = ST_COL;
                tmr_load = 1'b1;
                tmr_val  = TW'(CAS_CYC - 1);
            end
            ST_COL: if (tmr_done) begin
                state_d  = ST_CP;
                tmr_load = 1'b1;
                tmr_val  = TW'(CP_CYC - 1);
            end
            ST_CP: if (tmr_done) state_d = ST_OPEN;
            ST_OPEN: begin
                if (close_req && ras_min_ok) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RP_CYC - 1);
                end else if (accept && legal_in) begin
                    state_d  = ST_COL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CAS_CYC - 1);
                end
            end
            ST_PRE: if (tmr_done) state_d = ST_IDLE;
            ST_REF: if (!refresh_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign cap_req = accept && legal_in;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Latch the fields of each accepted legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            col_q   <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (cap_req) begin
            wr_q    <= req_write;
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Read capture after column precharge, and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_CP) && tmr_done && !wr_q;
            if ((state == ST_CP) && tmr_done && !wr_q) rsp_rdata <= dram_dq_in;
            rsp_err   <= accept && !legal_in;
        end
    end

    edo_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done)
    );

    edo_page_guard #(
        .ROW_W(ROW_W), .PAGE_MAX_CYC(PAGE_MAX_CYC),
        .RAS_MIN_CYC(RAS_MIN_CYC), .LIMIT(LIMIT)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .open(!dram_ras_n), .capture(cap_row),
        .cap_row(req_addr[ADDR_W-1:COL_W]), .cmp_row(req_addr[ADDR_W-1:COL_W]),
        .row_q(row_q), .hit(hit), .expired(expired), .ras_min_ok(ras_min_ok)
    );

    edo_lane_strobe #(.LANES(LANES)) u_lanes (
        .cas_phase(state == ST_COL), .be(be_q), .cas_n(cas_n)
    );

    // Strobe and bus decode from the registered state.
    assign dram_ras_n  = !(state inside {ST_ROW, ST_COL, ST_CP, ST_OPEN});
    assign dram_addr   = (state == ST_ROW) ? row_q : col_q;
    assign dram_lcas_n = cas_n[0];
    assign dram_ucas_n = cas_n[LANES-1];
    assign dram_we_n   = !((state == ST_COL) && wr_q);
    assign dram_oe_n   = !((state inside {ST_COL, ST_CP}) && !wr_q);
    assign dram_dq_oe  = (state == ST_COL) && wr_q;
    assign dram_dq_out = wdata_q;
    assign refresh_gnt = (state == ST_REF);

    // R11: a column strobe is only ever low inside a row cycle.
    a_r11_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cas_n) |-> !dram_ras_n);
    // R9: the grant is only given with every strobe released.
    a_r9_gnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_gnt |-> (dram_ras_n && (&cas_n)));
    // R7: write enable low only as an early write with outputs off.
    a_r7_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_oe_n && dram_dq_oe && !(&cas_n)));
    // R8: data is taken after the column strobes returned high.
    a_r8_edo_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(&cas_n) && !$past(dram_ras_n)));
    // R3: a rejected request moves no column strobe.
    a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (&cas_n && !rsp_valid));
endmodule

// File: tb/sim_edo_dram_ctrl.sv
// Bench: behavioural DRAM, reference latency/data model, cycle-count timing monitor.
module sim_edo_dram_ctrl;
    localparam int RCD = 1, RAS_MIN = 2, RP = 2, CASW = 1, CPW = 1, PMAX = 40;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, refresh_req = 0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic req_ready, rsp_valid, rsp_err, refresh_gnt;
    logic [15:0] rsp_rdata, dram_dq_out;
    logic dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [8:0] dram_addr;
    logic [15:0] dq_in_m = '0;

    always #10 clk = ~clk;

    edo_dram_ctrl #(.RCD_CYC(RCD), .RAS_MIN_CYC(RAS_MIN), .RP_CYC(RP),
                    .CAS_CYC(CASW), .CP_CYC(CPW), .PAGE_MAX_CYC(PMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .refresh_req(refresh_req), .refresh_gnt(refresh_gnt),
        .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_m));

    int checks = 0, fails = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM ----------------
    logic [15:0] dmem [int];
    logic [8:0]  cur_row, last_row, last_col;

    function automatic logic [15:0] dget(input int k);
        return dmem.exists(k) ? dmem[k] : 16'h0000;
    endfunction

    always @(negedge dram_ras_n) begin
        #1 cur_row = dram_addr;
        last_row = dram_addr;
    end

    task automatic lane_fall(input int lane);
        int k;
        logic [15:0] v;
        #1 last_col = dram_addr;
        k = int'({cur_row, dram_addr});
        if (!dram_we_n && dram_dq_oe) begin
            v = dget(k);
            if (lane == 0) v[7:0] = dram_dq_out[7:0]; else v[15:8] = dram_dq_out[15:8];
            dmem[k] = v;
        end else if (!dram_oe_n) begin
            #11;
            if (lane == 0) dq_in_m[7:0] = dget(k) >> 0; else dq_in_m[15:8] = dget(k) >> 8;
        end
    endtask

    always @(negedge dram_lcas_n) lane_fall(0);
    always @(negedge dram_ucas_n) lane_fall(1);

    // ---------------- reference model ----------------
    typedef struct { int cyc; logic [15:0] data; logic [1:0] be; } exp_t;
    exp_t expq[$];
    logic [15:0] shadow [int];
    bit model_open = 0;
    logic [8:0] model_row;
    bit ras_rise_seen = 0;

    function automatic logic [15:0] bmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        int e, lat;
        logic [15:0] v;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        e = cyc + 1;
        lat = (model_open && model_row == a[17:9]) ? 2 : 3;
        if (be != 2'b00) begin
            model_open = 1; model_row = a[17:9];
            if (wr) begin
                v = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
                v = (v & ~bmask(be)) | (d & bmask(be));
                shadow[int'(a)] = v;
            end else begin
                v = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
                expq.push_back('{e + lat, v, be});
            end
        end
        @(posedge clk); #1;
        if (be == 2'b00) check(rsp_err === 1'b1, "R3 reject pulse", 32'(rsp_err), 1);
        req_valid = 0;
    endtask

    // Per-cycle compare and timing monitor.
    int viol7 = 0, viol10 = 0, viol11 = 0;
    int rl = 0, rh = 100, cl = 0, ch = 100;
    bit p_ras = 1, p_cl = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        bit exp_now, c_low;
        if (rst_n) begin
            exp_now = (expq.size() > 0) && (expq[0].cyc == cyc);
            if (rsp_valid !== exp_now)
                check(0, "R4 response timing", 32'(rsp_valid), 32'(exp_now));
            else if (exp_now) begin
                check((rsp_rdata & bmask(expq[0].be)) == (expq[0].data & bmask(expq[0].be)),
                      "R4/R8 read data", 32'(rsp_rdata), 32'(expq[0].data));
                void'(expq.pop_front());
            end
            if (dram_ras_n) model_open = 0;
            c_low = !(dram_lcas_n && dram_ucas_n);
            if (!dram_ras_n) begin
                if (p_ras && rh < RP) viol11++;
                rl = p_ras ? 1 : rl + 1;
                if (rl > PMAX) viol10++;
            end else begin
                if (!p_ras) begin
                    ras_rise_seen = 1;
                    if (rl < RAS_MIN) viol11++;
                end
                rh = p_ras ? rh + 1 : 1;
            end
            if (c_low) begin
                if (dram_ras_n) viol11++;
                if (!p_cl && (ch < CPW || rl - 1 < RCD)) viol11++;
                cl = p_cl ? cl + 1 : 1;
            end else begin
                if (p_cl && cl < CASW) viol11++;
                ch = p_cl ? ch + 1 : 1;
            end
            if (!dram_we_n && !(dram_oe_n && dram_dq_oe && c_low)) viol7++;
            p_ras = dram_ras_n; p_cl = c_low;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [17:0] A1 = {9'd5, 9'd3};
    localparam logic [17:0] B1 = {9'd7, 9'd1};
    localparam logic [17:0] B2 = {9'd7, 9'd2};

    initial begin : watchdog
        #3000000;
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n &&
              !dram_dq_oe && !refresh_gnt && !rsp_valid && !rsp_err,
              "R1 reset state", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n,
              dram_dq_oe, refresh_gnt, rsp_valid, rsp_err}, 9'b111110000);
        @(negedge clk); rst_n = 1;

        // Word write from idle, address split
        issue(1, A1, 16'hBEEF, 2'b11);
        ras_rise_seen = 0;
        idle(4);
        check(last_row == 9'd5 && last_col == 9'd3, "R2 row/column split",
              {last_row, last_col}, {9'd5, 9'd3});
        // Hit read
        issue(0, A1, 16'h0, 2'b11);
        idle(4);
        check(!ras_rise_seen, "R5 page kept open on hit", 32'(ras_rise_seen), 0);
        // Byte lanes
        issue(1, A1, 16'hFF12, 2'b01);
        issue(0, A1, 16'h0, 2'b11);
        issue(1, A1, 16'h34FF, 2'b10);
        issue(0, A1, 16'h0, 2'b11);
        idle(4);
        check(dget(int'(A1)) == 16'h3412, "R3 per-lane write", dget(int'(A1)), 16'h3412);
        // Reject
        issue(1, A1, 16'hFFFF, 2'b00);
        idle(3);
        check(dget(int'(A1)) == 16'h3412, "R3 reject leaves memory", dget(int'(A1)), 16'h3412);
        issue(0, A1, 16'h0, 2'b10);
        // Row miss
        ras_rise_seen = 0;
        issue(0, B1, 16'h0, 2'b11);
        check(ras_rise_seen, "R6 row closed before miss", 32'(ras_rise_seen), 1);
        issue(1, B2, 16'hC0DE, 2'b11);
        issue(0, B2, 16'h0, 2'b11);
        issue(0, A1, 16'h0, 2'b01);
        idle(6);
        // Refresh with a pending same-row request
        @(negedge clk);
        refresh_req = 1; req_valid = 1; req_write = 0; req_addr = A1; req_be = 2'b11;
        #1 check(!req_ready, "R9 no accept during refresh", 32'(req_ready), 0);
        for (int i = 0; i < 20 && !refresh_gnt; i++) @(negedge clk);
        check(refresh_gnt && dram_ras_n && dram_lcas_n && dram_ucas_n,
              "R9 grant with strobes released", {refresh_gnt, dram_ras_n, dram_lcas_n, dram_ucas_n}, 4'hF);
        idle(4);
        check(!req_ready && refresh_gnt, "R9 grant held", {req_ready, refresh_gnt}, 2'b01);
        req_valid = 0; refresh_req = 0;
        idle(2);
        check(!refresh_gnt, "R9 grant released", 32'(refresh_gnt), 0);
        issue(0, A1, 16'h0, 2'b11);
        issue(0, B2, 16'h0, 2'b11);
        // Watchdog close of an idle page
        idle(PMAX + 10);
        check(dram_ras_n, "R10 idle page closed", 32'(dram_ras_n), 1);
        issue(0, B2, 16'h0, 2'b11);
        idle(8);
        check(expq.size() == 0, "R4 all responses seen", expq.size(), 0);
        check(viol7 == 0, "R7 early write pattern", viol7, 0);
        check(viol10 == 0, "R10 page length", viol10, 0);
        check(viol11 == 0, "R11 strobe timing", viol11, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule